// File: doc/BRIEF.md
# Sub-Register Aliasing Register File

This block holds eight 32-bit general registers. Each register can be read and written as a whole word, as its low half-word, or as a single byte. Reads go through two combinational ports and writes through one synchronous port. Every port takes a 3-bit register index and a 2-bit slice selector. A narrow write is merged into the stored word, so the bits outside the selected slice keep their old values. A narrow read returns the chosen slice zero-extended to 32 bits.

Only the four data registers (indices 0 to 3) have a second byte (bits 15:8) that can be addressed on its own. Selecting that slice on one of the pointer and index registers (indices 4 to 7) is an illegal access. The block flags it on the port concerned. An illegal write is dropped and an illegal read returns zero. A read of the register being written in the same cycle returns the contents from before the write.

Top module: `alias_regfile`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) clears all eight registers to zero. It takes precedence over any write in the same cycle.
- R2: Selector 2'b00 is full width. A write stores all 32 bits of `wrData`, and a read returns all 32 bits.
- R3: Selector 2'b01 is the low half-word. A write replaces bits 15:0 with `wrData[15:0]` and leaves bits 31:16 unchanged. A read returns bits 15:0 with bits 31:16 forced to zero.
- R4: Selector 2'b10 is the low byte. A write replaces bits 7:0 with `wrData[7:0]` and leaves bits 31:8 unchanged. A read returns bits 7:0 with bits 31:8 forced to zero.
- R5: Selector 2'b11 is the second byte and is legal for indices 0 to 3 only. A write places `wrData[7:0]` into bits 15:8 and leaves all other bits unchanged. A read returns bits 15:8 in bits 7:0 of the output, with bits 31:8 zero.
- R6: Selector 2'b11 with an index of 4 to 7 is illegal. On the write port, `wrIllegal` is high while `wrEn` is high, and the register does not change. On a read port, that port's illegal flag is high and its data is zero.
- R7: A write changes only the addressed register. The other seven registers keep their values.
- R8: A read of the register being written in the same cycle returns the value from before the write. The new value becomes visible after the clock edge.
- R9: The two read ports are independent. Each port returns the value selected by its own index and selector in the same cycle.
- R10: When `wrEn` is low, no register changes and `wrIllegal` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write strobe |
| wrIdx | input | 3 | Index of the register to write |
| wrSel | input | 2 | Slice selector for the write |
| wrData | input | 32 | Write data, aligned to bit 0 for narrow slices |
| wrIllegal | output | 1 | Write requests a second byte that does not exist |
| rdIdxA | input | 3 | Read port A register index |
| rdSelA | input | 2 | Read port A slice selector |
| rdDataA | output | 32 | Read port A data, zero-extended |
| rdIllegalA | output | 1 | Read port A requests a second byte that does not exist |
| rdIdxB | input | 3 | Read port B register index |
| rdSelB | input | 2 | Read port B slice selector |
| rdDataB | output | 32 | Read port B data, zero-extended |
| rdIllegalB | output | 1 | Read port B requests a second byte that does not exist |

## Verification
The assertions check on every cycle that:
- registers other than the written one stay stable;
- byte lanes outside a write's slice keep their previous value;
- enabled lanes take the aligned write data;
- an illegal request never commits;
- narrow reads come back zero-extended.

Only the bench scenarios can show the slice mapping end to end: that a second-byte write lands in bits 15:8 and reads back in bits 7:0, that a same-cycle read sees the old word, and that reset clears values written earlier. Those checks compare against a model built from the requirements.

// File: rtl/aliasrf_pkg.sv
package aliasrf_pkg;
  localparam int DATA_W = 32;
  localparam int LANE_W = 8;
  localparam int LANES  = DATA_W / LANE_W;

  typedef enum logic [1:0] {
    SEL_FULL = 2'b00,
    SEL_HALF = 2'b01,
    SEL_LOB  = 2'b10,
    SEL_HIB  = 2'b11
  } sliceSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             wrCommit;
    logic [LANES-1:0] wrLanes;
    logic             wrHigh;
    logic [LANES-1:0] rdMaskA;
    logic             rdHighA;
    logic [LANES-1:0] rdMaskB;
    logic             rdHighB;
  } rfStrobes_t;

  function automatic logic [LANES-1:0] laneMask(input sliceSel_e sel);
    logic [LANES-1:0] m;
    m = '0;
    case (sel)
      SEL_FULL: m = '1;
      SEL_HALF: m[1:0] = 2'b11;
      SEL_LOB:  m[0] = 1'b1;
      SEL_HIB:  m[1] = 1'b1;
      default:  m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/aliasrf_ctrl.sv
module aliasrf_ctrl
  import aliasrf_pkg::*;
#(
  parameter int NUM_REGS  = 8,
  parameter int BYTE_REGS = 4,
  localparam int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  sliceSel_e        wrSel,
  input  logic [IDX_W-1:0] rdIdxA,
  input  sliceSel_e        rdSelA,
  input  logic [IDX_W-1:0] rdIdxB,
  input  sliceSel_e        rdSelB,
  output rfStrobes_t       strobes,
  output logic             wrIllegal,
  output logic             rdIllegalA,
  output logic             rdIllegalB
);
  logic wrBad, badA, badB;

  always_comb begin
    wrBad = (wrSel == SEL_HIB) && (int'(wrIdx) >= BYTE_REGS);
    badA  = (rdSelA == SEL_HIB) && (int'(rdIdxA) >= BYTE_REGS);
    badB  = (rdSelB == SEL_HIB) && (int'(rdIdxB) >= BYTE_REGS);

    strobes.wrCommit = wrEn && !wrBad;
    strobes.wrLanes  = laneMask(wrSel);
    strobes.wrHigh   = (wrSel == SEL_HIB);
    strobes.rdMaskA  = badA ? '0 : laneMask(rdSelA);
    strobes.rdHighA  = (rdSelA == SEL_HIB);
    strobes.rdMaskB  = badB ? '0 : laneMask(rdSelB);
    strobes.rdHighB  = (rdSelB == SEL_HIB);

    wrIllegal  = wrEn && wrBad;
    rdIllegalA = badA;
    rdIllegalB = badB;
  end

  // R6 / R10: a flagged or disabled write never reaches the datapath
  p_illegal_no_commit_r6: assert property (@(posedge clk) disable iff (rst)
    wrIllegal |-> !strobes.wrCommit);
  p_idle_no_commit_r10: assert property (@(posedge clk) disable iff (rst)
    !wrEn |-> (!strobes.wrCommit && !wrIllegal));
endmodule

// File: rtl/aliasrf_datapath.sv
module aliasrf_datapath
  import aliasrf_pkg::*;
#(
  parameter int NUM_REGS = 8,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  rfStrobes_t        strobes,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [IDX_W-1:0]  rdIdxA,
  input  logic [IDX_W-1:0]  rdIdxB,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB
);
  logic [DATA_W-1:0] regs [NUM_REGS];
  logic [DATA_W-1:0] alignedData;
  logic [DATA_W-1:0] maskA, maskB, rawA, rawB;

  assign alignedData = strobes.wrHigh ? (wrData << LANE_W) : wrData;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NUM_REGS; r++) regs[r] <= '0;
    end else if (strobes.wrCommit) begin
      for (int l = 0; l < LANES; l++)
        if (strobes.wrLanes[l])
          regs[wrIdx][l*LANE_W +: LANE_W] <= alignedData[l*LANE_W +: LANE_W];
    end
  end

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : gMask
      assign maskA[g*LANE_W +: LANE_W] = {LANE_W{strobes.rdMaskA[g]}};
      assign maskB[g*LANE_W +: LANE_W] = {LANE_W{strobes.rdMaskB[g]}};
    end
  endgenerate

  always_comb begin
    rawA    = regs[rdIdxA] & maskA;
    rawB    = regs[rdIdxB] & maskB;
    rdDataA = strobes.rdHighA ? (rawA >> LANE_W) : rawA;
    rdDataB = strobes.rdHighB ? (rawB >> LANE_W) : rawB;
  end

  generate
    for (g = 0; g < NUM_REGS; g++) begin : gRegChk
      // R7: registers not targeted by a committed write hold
      p_other_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !(strobes.wrCommit && int'(wrIdx) == g) |=> $stable(regs[g]));
    end
    for (g = 0; g < LANES; g++) begin : gLaneChk
      // R3: lanes outside the slice keep their bits
      p_lane_keep_r3: assert property (@(posedge clk) disable iff (rst)
        (strobes.wrCommit && !strobes.wrLanes[g]) |=>
          regs[$past(wrIdx)][g*LANE_W +: LANE_W] == $past(regs[wrIdx][g*LANE_W +: LANE_W]));
      // R2: selected lanes take the aligned data
      p_lane_take_r2: assert property (@(posedge clk) disable iff (rst)
        (strobes.wrCommit && strobes.wrLanes[g]) |=>
          regs[$past(wrIdx)][g*LANE_W +: LANE_W] == $past(alignedData[g*LANE_W +: LANE_W]));
    end
  endgenerate
endmodule

// File: rtl/alias_regfile.sv
module alias_regfile
  import aliasrf_pkg::*;
#(
  parameter int NUM_REGS  = 8,
  parameter int BYTE_REGS = 4,
  localparam int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [1:0]        wrSel,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrIllegal,
  input  logic [IDX_W-1:0]  rdIdxA,
  input  logic [1:0]        rdSelA,
  output logic [DATA_W-1:0] rdDataA,
  output logic              rdIllegalA,
  input  logic [IDX_W-1:0]  rdIdxB,
  input  logic [1:0]        rdSelB,
  output logic [DATA_W-1:0] rdDataB,
  output logic              rdIllegalB
);
  rfStrobes_t strobes;

  aliasrf_ctrl #(.NUM_REGS(NUM_REGS), .BYTE_REGS(BYTE_REGS)) uCtrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrIdx(wrIdx), .wrSel(sliceSel_e'(wrSel)),
    .rdIdxA(rdIdxA), .rdSelA(sliceSel_e'(rdSelA)),
    .rdIdxB(rdIdxB), .rdSelB(sliceSel_e'(rdSelB)),
    .strobes(strobes), .wrIllegal(wrIllegal),
    .rdIllegalA(rdIllegalA), .rdIllegalB(rdIllegalB)
  );

  aliasrf_datapath #(.NUM_REGS(NUM_REGS)) uData (
    .clk(clk), .rst(rst), .strobes(strobes), .wrIdx(wrIdx), .wrData(wrData),
    .rdIdxA(rdIdxA), .rdIdxB(rdIdxB), .rdDataA(rdDataA), .rdDataB(rdDataB)
  );

  // R4 / R5: byte reads are zero-extended above bit 7
  p_byte_zext_r4: assert property (@(posedge clk) disable iff (rst)
    (rdSelA[1] == 1'b1) |-> (rdDataA[DATA_W-1:LANE_W] == '0));
  // R3: half-word reads are zero-extended above bit 15
  p_half_zext_r3: assert property (@(posedge clk) disable iff (rst)
    (rdSelB == 2'b01) |-> (rdDataB[DATA_W-1:2*LANE_W] == '0));
  // R6: an illegal read yields zero
  p_illegal_read_zero_r6: assert property (@(posedge clk) disable iff (rst)
    rdIllegalA |-> (rdDataA == '0));
endmodule

// File: tb/alias_regfile_test.sv
module alias_regfile_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [2:0]  wrIdx = '0;
  logic [1:0]  wrSel = '0;
  logic [31:0] wrData = '0;
  logic        wrIllegal;
  logic [2:0]  rdIdxA = '0, rdIdxB = '0;
  logic [1:0]  rdSelA = '0, rdSelB = '0;
  logic [31:0] rdDataA, rdDataB;
  logic        rdIllegalA, rdIllegalB;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;
  logic [31:0] model [8];

  always #4 clk = ~clk;

  alias_regfile uut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrIdx(wrIdx), .wrSel(wrSel), .wrData(wrData),
    .wrIllegal(wrIllegal), .rdIdxA(rdIdxA), .rdSelA(rdSelA), .rdDataA(rdDataA),
    .rdIllegalA(rdIllegalA), .rdIdxB(rdIdxB), .rdSelB(rdSelB), .rdDataB(rdDataB),
    .rdIllegalB(rdIllegalB)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(input int idx, input logic [1:0] sel);
    logic [31:0] m;
    m = model[idx];
    case (sel)
      2'b00:   return m;
      2'b01:   return {16'h0, m[15:0]};
      2'b10:   return {24'h0, m[7:0]};
      default: return (idx < 4) ? {24'h0, m[15:8]} : 32'h0;
    endcase
  endfunction

  function automatic bit isBad(input int idx, input logic [1:0] sel);
    return (sel == 2'b11) && (idx >= 4);
  endfunction

  task automatic doWrite(input bit en, input int idx, input logic [1:0] sel,
                         input logic [31:0] data, input string req);
    bit bad;
    @(negedge clk);
    wrEn = en; wrIdx = 3'(idx); wrSel = sel; wrData = data;
    bad = en && isBad(idx, sel);
    #1 chk({req, " wrIllegal"}, {31'h0, wrIllegal}, {31'h0, bad});
    @(negedge clk);
    wrEn = 1'b0;
    if (en && !bad) begin
      case (sel)
        2'b00:   model[idx] = data;
        2'b01:   model[idx][15:0] = data[15:0];
        2'b10:   model[idx][7:0] = data[7:0];
        default: model[idx][15:8] = data[7:0];
      endcase
    end
  endtask

  task automatic rdCheck(input int ia, input logic [1:0] sa, input int ib,
                         input logic [1:0] sb, input string req);
    rdIdxA = 3'(ia); rdSelA = sa; rdIdxB = 3'(ib); rdSelB = sb;
    #1;
    chk({req, " portA"}, rdDataA, expRead(ia, sa));
    chk({req, " portB"}, rdDataB, expRead(ib, sb));
    chk({req, " illA"}, {31'h0, rdIllegalA}, {31'h0, isBad(ia, sa)});
    chk({req, " illB"}, {31'h0, rdIllegalB}, {31'h0, isBad(ib, sb)});
  endtask

  task automatic tResetR1();
    for (int i = 0; i < 8; i++) model[i] = '0;
    for (int i = 0; i < 8; i++) rdCheck(i, 2'b00, 7 - i, 2'b00, "R1 reset");
  endtask

  task automatic tFullR2();
    for (int i = 0; i < 8; i++) doWrite(1, i, 2'b00, 32'h1111_1111 * (i + 1) + 32'h0F0F_0000, "R2");
    for (int i = 0; i < 8; i++) rdCheck(i, 2'b00, i, 2'b00, "R2 full readback");
  endtask

  task automatic tHalfR3();
    doWrite(1, 5, 2'b01, 32'hAAAA_1234, "R3");
    rdCheck(5, 2'b00, 5, 2'b01, "R3 half merge");
  endtask

  task automatic tLowByteR4();
    doWrite(1, 1, 2'b10, 32'hFFFF_FF5C, "R4");
    rdCheck(1, 2'b00, 1, 2'b10, "R4 low byte");
  endtask

  task automatic tHighByteR5();
    doWrite(1, 3, 2'b11, 32'hCCCC_CC5A, "R5");
    rdCheck(3, 2'b11, 3, 2'b00, "R5 high byte");
    doWrite(1, 0, 2'b11, 32'h0000_00E7, "R5");
    rdCheck(0, 2'b11, 0, 2'b10, "R5 high byte idx0");
  endtask

  task automatic tIllegalR6();
    doWrite(1, 6, 2'b11, 32'h0000_0099, "R6");
    rdCheck(6, 2'b00, 6, 2'b11, "R6 illegal suppressed");
    doWrite(1, 4, 2'b11, 32'h0000_0042, "R6");
    rdCheck(4, 2'b11, 4, 2'b00, "R6 illegal idx4");
  endtask

  task automatic tOtherRegsR7();
    doWrite(1, 2, 2'b00, 32'h7777_ABCD, "R7");
    for (int i = 0; i < 8; i++) rdCheck(i, 2'b00, i, 2'b01, "R7 other regs");
  endtask

  task automatic tRdwR8();
    @(negedge clk);
    wrEn = 1'b1; wrIdx = 3'd7; wrSel = 2'b00; wrData = 32'h5151_A0A0;
    rdCheck(7, 2'b00, 7, 2'b10, "R8 old value same cycle");
    @(negedge clk);
    wrEn = 1'b0;
    model[7] = 32'h5151_A0A0;
    rdCheck(7, 2'b00, 7, 2'b10, "R8 new value next cycle");
  endtask

  task automatic tDualR9();
    rdCheck(0, 2'b11, 5, 2'b00, "R9 dual");
    rdCheck(3, 2'b10, 6, 2'b01, "R9 dual");
    rdCheck(7, 2'b11, 1, 2'b11, "R9 dual");
  endtask

  task automatic tNoEnR10();
    doWrite(0, 3, 2'b00, 32'hDEAD_0000, "R10");
    rdCheck(3, 2'b00, 0, 2'b00, "R10 no enable");
  endtask

  task automatic tResetAgainR1();
    @(negedge clk);
    rst = 1'b1; wrEn = 1'b1; wrIdx = 3'd2; wrSel = 2'b00; wrData = 32'h1234_5678;
    @(negedge clk);
    rst = 1'b0; wrEn = 1'b0;
    for (int i = 0; i < 8; i++) model[i] = '0;
    for (int i = 0; i < 8; i++) rdCheck(i, 2'b00, i, 2'b01, "R1 reset mid-run");
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tResetR1();
    tFullR2();
    tHalfR3();
    tLowByteR4();
    tHighByteR5();
    tIllegalR6();
    tOtherRegsR7();
    tRdwR8();
    tDualR9();
    tNoEnR10();
    tResetAgainR1();
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end
endmodule